// File: doc/BRIEF.md
# Packed-slot stack processor core

This block is a small processor built around two stacks. It reads one 20-bit word from memory into an instruction latch and then runs the four 5-bit instructions packed in that word, one after another. Only then does it fetch again. Working values sit in a 21-bit top register T and an 8-entry data stack below it. Subroutine return addresses sit on a separate 8-entry return stack. A pointer register supplies the address for data reads and writes, and the program counter holds the address of the next word. Bit 20 of T receives the carry from addition.

Every arithmetic and logic result is formed in parallel from T and the top data-stack entry. The instruction only picks which result is clocked into T. There is no subtract and no OR; programs build these from invert, add and XOR. The core talks to the outside through one word-wide request/ready port. Memory timing, display and device decoding all sit behind that port.

Top module: `misc20_core`

## Requirements
- R1: Slot 0 is bits 19:15 of the latched word and slot 3 is bits 4:0. Slots run in the order 0, 1, 2, 3. While reset is held, the core requests a read at address 0. A completed fetch latches the word, adds one to the PC and starts slot 0. After a slot-3 instruction that is not a branch, the next cycle requests a fetch.
- R2: A transfer completes in the cycle `mem_ready` is high while `mem_req` is high. Until that cycle, `mem_req`, `mem_we`, `mem_addr` and (for writes) `mem_wdata` hold their values and no state advances.
- R3: IMM (0x0A) reads the word at the PC, pushes T, loads T with that word (bit 20 cleared) and adds one to the PC. Execution then continues with the next slot.
- R4: LD (0x08) and LDI (0x09) read the word at address A and push it into T. ST (0x0C) and STI (0x0D) write T[19:0] to address A and then pop T. LDI and STI then add one to A.
- R5: INV (0x10) inverts all 21 bits of T. XOR (0x11) and AND (0x12) combine T with the stack top and pop. SHL (0x14) gives {T[19:0],0}. SHR (0x15) gives {0,T[20:1]}.
- R6: ADD (0x13) writes the 20-bit sum of T[19:0] and the stack top into T[19:0], writes the carry into T[20], and pops. MADD (0x16) writes the same sum into T, without popping, only when T[0] is 1; otherwise T is unchanged.
- R7: DUP (0x1A) pushes T. DROP (0x1B) pops into T. OVER (0x1C) pushes T and copies the former stack top into T. GETA (0x18) pushes T and loads T with A. SETA (0x19) loads A from T[19:0] and pops. Each stack holds 8 entries and its pointer wraps without a trap.
- R8: JMP (0x00), BZ (0x03) and BNC (0x04) use the bits below their own slot as the low bits of the target; the upper bits come from the PC (the address following the current word). BZ is taken when all 21 bits of T are zero, and BNC is taken when T[20] is 0. In both cases the slots that follow are not executed, and the next word is fetched from the target if the branch is taken, or from the PC if it is not.
- R9: CALL (0x01) pushes the PC onto the return stack and jumps as JMP does. RET (0x02) pops the return stack into the PC, drops the remaining slots and fetches from there.
- R10: Codes 0x05–0x07, 0x0B, 0x0E, 0x0F, 0x17, 0x1D (NOP), 0x1E and 0x1F change no state apart from moving on to the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Transfer requested this cycle |
| mem_we | output | 1 | Requested transfer is a write |
| mem_addr | output | 20 | Word address of the transfer |
| mem_wdata | output | 20 | Write data |
| mem_rdata | input | 20 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Completes the pending transfer this cycle |

## Verification
Every port output follows from registered state. A transfer completed at one rising edge therefore shows its effect on the port one cycle later. A branch or the end of slot 3 shows up as a fetch request on the next cycle, and a memory write appears in the cycle its instruction executes. The bench steps a behavioural model at the same edges the core uses and compares all request fields at the falling edge that follows each rising edge, so each comparison sees settled values. Cycles that follow a refused transfer are tagged as stall checks.

Memory in the bench does not accept every request. This exercises the hold behaviour on fetches, on immediate reads and on data accesses. After the program settles into its final loop, the values it stored are compared against constants worked out by hand from the opcode definitions.

// File: rtl/misc20_core.sv
module misc20_core #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_req,
  output logic        mem_we,
  output logic [19:0] mem_addr,
  output logic [19:0] mem_wdata,
  input  logic [19:0] mem_rdata,
  input  logic        mem_ready
);
  localparam int PW = $clog2(DEPTH);

  localparam logic [4:0] OP_JMP  = 5'h00, OP_CALL = 5'h01, OP_RET  = 5'h02,
                         OP_BZ   = 5'h03, OP_BNC  = 5'h04, OP_LD   = 5'h08,
                         OP_LDI  = 5'h09, OP_IMM  = 5'h0A, OP_ST   = 5'h0C,
                         OP_STI  = 5'h0D, OP_INV  = 5'h10, OP_XOR  = 5'h11,
                         OP_AND  = 5'h12, OP_ADD  = 5'h13, OP_SHL  = 5'h14,
                         OP_SHR  = 5'h15, OP_MADD = 5'h16, OP_GETA = 5'h18,
                         OP_SETA = 5'h19, OP_DUP  = 5'h1A, OP_DROP = 5'h1B,
                         OP_OVER = 5'h1C;

  logic          exec_q;
  logic [1:0]    slot_q;
  logic [19:0]   iw_q, pc_q, a_q;
  logic [20:0]   t_q;
  logic [20:0]   ds_q [DEPTH];
  logic [19:0]   rs_q [DEPTH];
  logic [PW-1:0] sp_q, rp_q;

  logic [4:0]  op;
  logic [19:0] mask, tgt;
  logic [20:0] s, sum, t_n;
  logic        is_ld, is_st, is_br, taken, step, push, pop;

  always_comb begin
    case (slot_q)
      2'd0: begin op = iw_q[19:15]; mask = 20'h07FFF; end
      2'd1: begin op = iw_q[14:10]; mask = 20'h003FF; end
      2'd2: begin op = iw_q[9:5];   mask = 20'h0001F; end
      default: begin op = iw_q[4:0]; mask = 20'h00000; end
    endcase
  end

  assign tgt   = (pc_q & ~mask) | (iw_q & mask);
  assign s     = ds_q[sp_q];
  assign sum   = {1'b0, t_q[19:0]} + {1'b0, s[19:0]};
  assign is_ld = (op == OP_LD) || (op == OP_LDI) || (op == OP_IMM);
  assign is_st = (op == OP_ST) || (op == OP_STI);
  assign is_br = (op <= OP_BNC);

  assign mem_req   = !exec_q || is_ld || is_st;
  assign mem_we    = exec_q && is_st;
  assign mem_addr  = (!exec_q || op == OP_IMM) ? pc_q : a_q;
  assign mem_wdata = t_q[19:0];
  assign step      = exec_q && (!(is_ld || is_st) || mem_ready);

  always_comb begin
    case (op)
      OP_BZ:   taken = (t_q == 21'd0);
      OP_BNC:  taken = !t_q[20];
      default: taken = 1'b1;
    endcase
  end

  always_comb begin
    t_n  = t_q;
    push = 1'b0;
    pop  = 1'b0;
    case (op)
      OP_LD, OP_LDI, OP_IMM: begin t_n = {1'b0, mem_rdata}; push = 1'b1; end
      OP_ST, OP_STI, OP_SETA, OP_DROP: begin t_n = s; pop = 1'b1; end
      OP_INV:  t_n = ~t_q;
      OP_XOR:  begin t_n = t_q ^ s; pop = 1'b1; end
      OP_AND:  begin t_n = t_q & s; pop = 1'b1; end
      OP_ADD:  begin t_n = sum; pop = 1'b1; end
      OP_SHL:  t_n = {t_q[19:0], 1'b0};
      OP_SHR:  t_n = {1'b0, t_q[20:1]};
      OP_MADD: t_n = t_q[0] ? sum : t_q;
      OP_GETA: begin t_n = {1'b0, a_q}; push = 1'b1; end
      OP_DUP:  push = 1'b1;
      OP_OVER: begin t_n = s; push = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_q <= 1'b0;
      slot_q <= 2'd0;
      iw_q   <= '0;
      pc_q   <= '0;
      a_q    <= '0;
      t_q    <= '0;
      sp_q   <= '0;
      rp_q   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ds_q[i] <= '0;
        rs_q[i] <= '0;
      end
    end else if (!exec_q) begin
      if (mem_ready) begin
        iw_q   <= mem_rdata;
        pc_q   <= pc_q + 20'd1;
        slot_q <= 2'd0;
        exec_q <= 1'b1;
      end
    end else if (step) begin
      t_q <= t_n;
      if (push) begin
        ds_q[sp_q + 1'b1] <= t_q;
        sp_q <= sp_q + 1'b1;
      end else if (pop) begin
        sp_q <= sp_q - 1'b1;
      end
      if (op == OP_LDI || op == OP_STI) a_q <= a_q + 20'd1;
      if (op == OP_SETA) a_q <= t_q[19:0];
      if (op == OP_CALL) begin
        rs_q[rp_q + 1'b1] <= pc_q;
        rp_q <= rp_q + 1'b1;
      end
      if (op == OP_RET) rp_q <= rp_q - 1'b1;
      if (is_br) begin
        exec_q <= 1'b0;
        if (op == OP_RET) pc_q <= rs_q[rp_q];
        else if (taken) pc_q <= tgt;
      end else if (op == OP_IMM) begin
        pc_q <= pc_q + 20'd1;
      end
      if (!is_br) begin
        if (slot_q == 2'd3) exec_q <= 1'b0;
        else slot_q <= slot_q + 2'd1;
      end
    end
  end
endmodule

module misc20_core_chk #(
  parameter int DEPTH = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mem_req,
  input logic                     mem_we,
  input logic                     mem_ready,
  input logic [19:0]              mem_addr,
  input logic [19:0]              mem_wdata,
  input logic                     exec_q,
  input logic [19:0]              pc_q,
  input logic [1:0]               slot_q,
  input logic [4:0]               op,
  input logic [$clog2(DEPTH)-1:0] sp_q
);
  localparam int PW = $clog2(DEPTH);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R2
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_ready |=> $stable(mem_wdata));

  // R4
  write_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  // R1
  fetch_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_q && mem_ready |=> exec_q && slot_q == 2'd0 && pc_q == $past(pc_q) + 20'd1);

  // R1
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_q && op >= 5'h05 && slot_q != 2'd3 && (!mem_req || mem_ready)
    |=> exec_q && slot_q == $past(slot_q) + 2'd1);

  // R7
  dup_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_q && op == 5'h1A |=> sp_q == PW'($past(sp_q) + 1'b1));

  // R8
  branch_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_q && op <= 5'h04 |=> !exec_q && mem_req);
endmodule

bind misc20_core misc20_core_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .exec_q(exec_q), .pc_q(pc_q), .slot_q(slot_q), .op(op), .sp_q(sp_q)
);

// File: tb/misc20_core_tb.sv
`timescale 1ns/1ps
module misc20_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_we, mem_ready;
  logic [19:0] mem_addr, mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  misc20_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  localparam logic [4:0] JMP = 5'h00, CALL = 5'h01, RET = 5'h02, BZ = 5'h03,
    BNC = 5'h04, LD = 5'h08, LDI = 5'h09, IMM = 5'h0A, ST = 5'h0C, STI = 5'h0D,
    INV = 5'h10, XOR = 5'h11, AND = 5'h12, ADD = 5'h13, SHL = 5'h14, SHR = 5'h15,
    MADD = 5'h16, GETA = 5'h18, SETA = 5'h19, DUP = 5'h1A, DROP = 5'h1B,
    OVER = 5'h1C, NOP = 5'h1D;

  logic [19:0] dmem [512];
  logic [19:0] mmem [512];
  int vectors = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [7:0] lfsr = 8'hA5;
  bit stall_prev = 0;

  assign mem_rdata = dmem[mem_addr[8:0]];

  always @(posedge clk)
    if (rst_n && mem_req && mem_we && mem_ready) dmem[mem_addr[8:0]] <= mem_wdata;

  // behavioural reference model
  bit          m_exec;
  int          m_slot, m_sp, m_rp;
  logic [19:0] m_iw, m_pc, m_a;
  logic [20:0] m_t;
  logic [20:0] m_ds [8];
  logic [19:0] m_rs [8];

  function automatic logic [4:0] m_op();
    return m_iw[19 - 5*m_slot -: 5];
  endfunction

  function automatic bit m_memop();
    logic [4:0] o = m_op();
    return m_exec && (o == LD || o == LDI || o == IMM || o == ST || o == STI);
  endfunction

  function automatic logic [63:0] m_port();
    logic [4:0] o = m_op();
    bit we = m_exec && (o == ST || o == STI);
    logic [19:0] ad = (!m_exec || o == IMM) ? m_pc : m_a;
    return {21'd0, !m_exec || m_memop(), we, ad, we ? m_t[19:0] : 20'd0};
  endfunction

  function automatic string m_tag();
    logic [4:0] o = m_op();
    if (stall_prev) return "R2";
    if (!m_exec) return "R1";
    case (o)
      IMM: return "R3";
      LD, LDI, ST, STI: return "R4";
      INV, XOR, AND, SHL, SHR: return "R5";
      ADD, MADD: return "R6";
      DUP, DROP, OVER, GETA, SETA: return "R7";
      JMP, BZ, BNC: return "R8";
      CALL, RET: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic m_push(input logic [20:0] v);
    m_sp = (m_sp + 1) % 8;
    m_ds[m_sp] = v;
  endtask

  task automatic m_step(input bit rdy);
    logic [4:0] o;
    logic [20:0] s, sm;
    logic [19:0] tg;
    int bits;
    if (!m_exec) begin
      if (rdy) begin
        m_iw = mmem[m_pc[8:0]];
        m_pc++;
        m_slot = 0;
        m_exec = 1;
      end
      return;
    end
    o = m_op();
    if (m_memop() && !rdy) return;
    s = m_ds[m_sp];
    sm = 21'(m_t[19:0]) + 21'(s[19:0]);
    bits = 15 - 5*m_slot;
    tg = ((m_pc >> bits) << bits) | (m_iw & 20'((1 << bits) - 1));
    case (o)
      JMP:  begin m_pc = tg; m_exec = 0; end
      CALL: begin m_rp = (m_rp + 1) % 8; m_rs[m_rp] = m_pc; m_pc = tg; m_exec = 0; end
      RET:  begin m_pc = m_rs[m_rp]; m_rp = (m_rp + 7) % 8; m_exec = 0; end
      BZ:   begin if (m_t == 0) m_pc = tg; m_exec = 0; end
      BNC:  begin if (!m_t[20]) m_pc = tg; m_exec = 0; end
      LD:   begin m_push(m_t); m_t = 21'(mmem[m_a[8:0]]); end
      LDI:  begin m_push(m_t); m_t = 21'(mmem[m_a[8:0]]); m_a++; end
      IMM:  begin m_push(m_t); m_t = 21'(mmem[m_pc[8:0]]); m_pc++; end
      ST:   begin mmem[m_a[8:0]] = m_t[19:0]; m_t = s; m_sp = (m_sp + 7) % 8; end
      STI:  begin mmem[m_a[8:0]] = m_t[19:0]; m_t = s; m_sp = (m_sp + 7) % 8; m_a++; end
      INV:  m_t = ~m_t;
      XOR:  begin m_t = m_t ^ s; m_sp = (m_sp + 7) % 8; end
      AND:  begin m_t = m_t & s; m_sp = (m_sp + 7) % 8; end
      ADD:  begin m_t = sm; m_sp = (m_sp + 7) % 8; end
      SHL:  m_t = m_t << 1;
      SHR:  m_t = m_t >> 1;
      MADD: if (m_t[0]) m_t = sm;
      GETA: begin m_push(m_t); m_t = 21'(m_a); end
      SETA: begin m_a = m_t[19:0]; m_t = s; m_sp = (m_sp + 7) % 8; end
      DUP:  m_push(m_t);
      DROP: begin m_t = s; m_sp = (m_sp + 7) % 8; end
      OVER: begin m_push(m_t); m_t = s; end
      default: ;
    endcase
    if (o > BNC) begin
      if (m_slot == 3) m_exec = 0;
      else m_slot++;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_exec = 0; m_slot = 0; m_sp = 0; m_rp = 0;
      m_iw = 0; m_pc = 0; m_a = 0; m_t = 0;
      for (int i = 0; i < 8; i++) begin m_ds[i] = 0; m_rs[i] = 0; end
    end else begin
      m_step(mem_ready);
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(m_tag(), {21'd0, mem_req, mem_we, mem_addr, mem_we ? mem_wdata : 20'd0}, m_port());
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = lfsr[0] | lfsr[1];
      stall_prev = mem_req && !mem_ready;
    end
  end

  function automatic logic [19:0] w4(input logic [4:0] a, b, c, d);
    return {a, b, c, d};
  endfunction

  task automatic put(input int ad, input logic [19:0] v);
    dmem[ad] = v;
    mmem[ad] = v;
  endtask

  task automatic final_check(input string tag, input int ad, input logic [19:0] exp);
    check(tag, 64'(dmem[ad]), 64'(exp));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) put(i, 20'd0);
    put(0, w4(IMM, SETA, IMM, NOP)); put(1, 20'h00100); put(2, 20'h00005);
    put(3, w4(DUP, ADD, STI, NOP));
    put(4, w4(IMM, IMM, XOR, STI)); put(5, 20'hF0F0F); put(6, 20'h0FF00);
    put(7, w4(IMM, IMM, AND, STI)); put(8, 20'hF0F0F); put(9, 20'h0FF00);
    put(10, w4(IMM, INV, SHL, STI)); put(11, 20'h00001);
    put(12, w4(IMM, SHR, STI, NOP)); put(13, 20'h80001);
    put(14, w4(IMM, IMM, ADD, NOP)); put(15, 20'hFFFFF); put(16, 20'h00002);
    put(17, {BNC, 15'h0030});
    put(18, w4(STI, NOP, NOP, NOP));
    put(19, {IMM, BZ, 10'h030}); put(20, 20'h00000);
    put(48, w4(IMM, STI, NOP, NOP)); put(49, 20'h12345);
    put(50, {CALL, 15'd64});
    put(64, w4(IMM, STI, RET, NOP)); put(65, 20'h0ABCD);
    put(51, w4(GETA, STI, NOP, NOP));
    put(52, {IMM, BNC, 10'h060}); put(53, 20'h00007);
    put(96, w4(IMM, STI, NOP, NOP)); put(97, 20'h77777);
    put(98, w4(IMM, SETA, LD, DUP)); put(99, 20'h00100);
    put(100, w4(IMM, SETA, ADD, STI)); put(101, 20'h00110);
    put(102, w4(IMM, IMM, OVER, ADD)); put(103, 20'h00001); put(104, 20'h00002);
    put(105, w4(STI, NOP, NOP, NOP));
    put(106, w4(IMM, IMM, MADD, STI)); put(107, 20'h00005); put(108, 20'h00003);
    put(109, w4(IMM, MADD, STI, 5'h1F)); put(110, 20'h00002);
    put(111, w4(IMM, 5'h1E, 5'h07, STI)); put(112, 20'h5A5A5);
    put(113, w4(5'h05, 5'h0B, 5'h17, 5'h0E));
    put(114, {JMP, 15'd114});

    mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state requests a fetch at address 0
    check("R1", {62'd0, mem_req, mem_we}, 64'd2);
    check("R1", 64'(mem_addr), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3000) @(negedge clk);
    done = 1;
    final_check("R6", 'h100, 20'h0000A);
    final_check("R5", 'h101, 20'hFF00F);
    final_check("R5", 'h102, 20'h00F00);
    final_check("R5", 'h103, 20'hFFFFC);
    final_check("R5", 'h104, 20'h40000);
    final_check("R8", 'h105, 20'h00001);
    final_check("R8", 'h106, 20'h12345);
    final_check("R9", 'h107, 20'h0ABCD);
    final_check("R9", 'h108, 20'h00108);
    final_check("R8", 'h109, 20'h77777);
    final_check("R4", 'h110, 20'h00014);
    final_check("R7", 'h111, 20'h00003);
    final_check("R6", 'h112, 20'h00008);
    final_check("R6", 'h113, 20'h00002);
    final_check("R10", 'h114, 20'h5A5A5);
    final_check("R3", 'h10A, 20'h00000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule